// File: doc/BRIEF.md
# TDM Serial Port Timing Generator

This block derives the bit timing of a time-division-multiplexed serial port from its master clock and its 8 kHz frame pulse. It is clocked once per master-clock period. It gives one-cycle transmit and sample strobes, a bit-in-channel counter and a channel-in-frame counter. It also gives two edge-select flags, which tell the data path whether to launch on the falling or the rising master edge inside the strobed cycle. Serial rates of 2.048, 4.096 and 8.192 Mb/s are supported.

At 2.048 Mb/s with the clock-mode input low, each bit spans two master clocks. The sample strobe falls on the second clock of each bit, which is the three-quarter point of the bit cell. In every other case one master clock carries one bit, and both strobes are active in every cycle. The polarity of the frame pulse is found at run time. An active-low pulse selects the first backbone convention, with transmit on the falling edge and sample on the rising edge. An active-high pulse selects the second convention, with the two edges swapped. After a pulse the counters restart. A pulse that arrives early or late flags a slip.

Top module: `st_tdm_timing`

## Requirements
- R1: Rate code 0 (or 3) is 2.048 Mb/s with 32 channels, code 1 is 4.096 Mb/s with 64 channels and code 2 is 8.192 Mb/s with 128 channels. A bit lasts two cycles only for code 0/3 with `clk_mode` low. Otherwise it lasts one cycle.
- R2: `tx_en` is high in the first cycle of each bit. In two-cycle bits `smp_en` is high only in the second cycle. In one-cycle bits `smp_en` and `tx_en` are both high in every cycle.
- R3: `bit_cnt` counts 0 to 7, once per bit. `chan_cnt` advances after bit 7 and wraps to 0 after the last channel of the selected rate.
- R4: A frame start is a change of `fp` after at least 4 cycles at a steady level. The change that ends a short pulse is ignored. In the cycle after the start edge, `bit_cnt`, `chan_cnt` and the bit phase are 0.
- R5: The pulse level, which is the new `fp` level at the start, is 0 for the first convention (`fmt_alt`=0) and 1 for the second (`fmt_alt`=1). `fmt_lock` rises when two consecutive starts have the same level. A level mismatch clears it.
- R6: With `fmt_alt`=0, `tx_on_fall`=1 and `smp_on_fall`=0. With `fmt_alt`=1, both flags are inverted. Before the first lock, `fmt_alt` is 0.
- R7: After the first start, a start that does not fall in the last cycle of the frame raises `slip` for exactly one cycle. On-time starts and the first start leave `slip` low.
- R8: After reset, the counters are 0, `tx_en`=1, `smp_en`=0 (2.048 Mb/s, two-cycle bits), `fmt_lock`=0, `fmt_alt`=0 and `slip`=0.
- R9: At rate codes 1 and 2, `clk_mode` has no effect, and bits always last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst | input | 1 | synchronous reset, active high |
| fp | input | 1 | frame pulse |
| rate_sel | input | 2 | serial rate code |
| clk_mode | input | 1 | 0: clock twice bit rate, 1: clock equals bit rate |
| tx_en | output | 1 | transmit strobe |
| smp_en | output | 1 | sample strobe |
| tx_on_fall | output | 1 | transmit on falling master edge |
| smp_on_fall | output | 1 | sample on falling master edge |
| bit_cnt | output | 3 | bit index within channel |
| chan_cnt | output | 7 | channel index within frame |
| fmt_alt | output | 1 | detected pulse polarity (1 = active high) |
| fmt_lock | output | 1 | polarity confirmed over two frames |
| slip | output | 1 | one-cycle resync flag |

## Verification
A frame start is decided from the `fp` level seen at the clock edge, and every result of that start is registered at that same edge. The zeroed counters, `slip`, `fmt_lock` and `fmt_alt` are all due one cycle after the edge, and the bench samples them at the falling edge that follows. The bench numbers cycles from that sample point as k = 0. It then expects `bit_cnt` = (k / cycles-per-bit) mod 8 and `chan_cnt` = k / (8 x cycles-per-bit) at each k. An on-time pulse is driven so that its start edge meets k = frame length minus one. An off-time gap is used to force a slip.

// File: rtl/st_tdm_pkg.sv
package st_tdm_pkg;

  typedef enum logic [1:0] {
    RATE_2M  = 2'd0,
    RATE_4M  = 2'd1,
    RATE_8M  = 2'd2,
    RATE_RSV = 2'd3
  } rate_e;

  // channels per frame for a rate code, scaled from the base count
  function automatic int unsigned chans_per_frame(input logic [1:0] rate,
                                                  input int unsigned base);
    case (rate)
      RATE_4M: chans_per_frame = base * 2;
      RATE_8M: chans_per_frame = base * 4;
      default: chans_per_frame = base;
    endcase
  endfunction

  // a bit takes two master clocks only at the lowest rate in double mode
  function automatic logic two_clk_bits(input logic [1:0] rate,
                                        input logic mode);
    two_clk_bits = ((rate == RATE_2M) || (rate == RATE_RSV)) && !mode;
  endfunction

endpackage

// File: rtl/st_fp_detect.sv
module st_fp_detect #(
  parameter int unsigned MIN_IDLE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fp,
  input  logic at_frame_end,
  output logic frame_start,
  output logic slip,
  output logic fmt_alt,
  output logic fmt_lock
);
  localparam int unsigned RUN_W = $clog2(MIN_IDLE + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MIN_IDLE);

  logic             fp_q;
  logic [RUN_W-1:0] run_cnt;
  logic             synced;
  logic             seen;
  logic             last_pol;

  assign frame_start = (fp != fp_q) && (run_cnt >= RUN_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      fp_q     <= 1'b1;
      run_cnt  <= '0;
      synced   <= 1'b0;
      seen     <= 1'b0;
      last_pol <= 1'b0;
      fmt_alt  <= 1'b0;
      fmt_lock <= 1'b0;
      slip     <= 1'b0;
    end else begin
      fp_q <= fp;
      if (fp != fp_q)            run_cnt <= RUN_W'(1);
      else if (run_cnt < RUN_MAX) run_cnt <= run_cnt + 1'b1;
      slip <= frame_start && synced && !at_frame_end;
      if (frame_start) begin
        synced   <= 1'b1;
        seen     <= 1'b1;
        last_pol <= fp;
        if (seen && (fp == last_pol)) begin
          fmt_lock <= 1'b1;
          fmt_alt  <= fp;
        end else begin
          fmt_lock <= 1'b0;
        end
      end
    end
  end

  AST_SLIP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    slip |=> !slip); // R7
  AST_LOCK_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(fmt_lock) |-> $past(frame_start)); // R5
  AST_FMT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(fmt_alt)); // R5

endmodule

// File: rtl/st_bit_timer.sv
module st_bit_timer
  import st_tdm_pkg::*;
#(
  parameter int unsigned BASE_CHANS = 32,
  parameter int unsigned BITS_PER_CH = 8
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   frame_start,
  input  logic [1:0]                             rate_sel,
  input  logic                                   clk_mode,
  output logic                                   tx_en,
  output logic                                   smp_en,
  output logic [$clog2(BITS_PER_CH)-1:0]         bit_cnt,
  output logic [$clog2(BASE_CHANS*4)-1:0]        chan_cnt,
  output logic                                   at_frame_end
);
  localparam int unsigned BIT_W = $clog2(BITS_PER_CH);
  localparam int unsigned CH_W  = $clog2(BASE_CHANS * 4);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS_PER_CH - 1);

  logic            dbl;
  logic            ph;
  logic            bit_end;
  logic            chan_end;
  logic [CH_W-1:0] chan_last;

  assign dbl       = two_clk_bits(rate_sel, clk_mode);
  assign chan_last = CH_W'(chans_per_frame(rate_sel, BASE_CHANS) - 1);
  assign bit_end   = !dbl || ph;
  assign chan_end  = bit_end && (bit_cnt == BIT_LAST);
  assign at_frame_end = chan_end && (chan_cnt == chan_last);

  assign tx_en  = !ph;
  assign smp_en = dbl ? ph : 1'b1;

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      ph       <= 1'b0;
      bit_cnt  <= '0;
      chan_cnt <= '0;
    end else begin
      ph <= dbl && !ph;
      if (bit_end) bit_cnt <= (bit_cnt == BIT_LAST) ? '0 : bit_cnt + 1'b1;
      if (chan_end) chan_cnt <= (chan_cnt == chan_last) ? '0 : chan_cnt + 1'b1;
    end
  end

  AST_START_ZERO: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (bit_cnt == '0 && chan_cnt == '0 && tx_en)); // R4
  AST_SMP_FOLLOWS_TX: assert property (@(posedge clk) disable iff (rst)
    (dbl && tx_en && !frame_start) |=> (smp_en && !tx_en)); // R2
  AST_BIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (bit_end && !frame_start && bit_cnt != BIT_LAST) |=>
      (bit_cnt == $past(bit_cnt) + 1'b1)); // R3
  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (rst)
    $stable(rate_sel) |-> (chan_cnt <= chan_last)); // R3

endmodule

// File: rtl/st_tdm_timing.sv
module st_tdm_timing
  import st_tdm_pkg::*;
#(
  parameter int unsigned BASE_CHANS  = 32,
  parameter int unsigned BITS_PER_CH = 8,
  parameter int unsigned MIN_IDLE    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fp,
  input  logic [1:0] rate_sel,
  input  logic       clk_mode,
  output logic       tx_en,
  output logic       smp_en,
  output logic       tx_on_fall,
  output logic       smp_on_fall,
  output logic [2:0] bit_cnt,
  output logic [6:0] chan_cnt,
  output logic       fmt_alt,
  output logic       fmt_lock,
  output logic       slip
);
  localparam int unsigned BIT_W = $clog2(BITS_PER_CH);
  localparam int unsigned CH_W  = $clog2(BASE_CHANS * 4);

  logic             frame_start;
  logic             at_frame_end;
  logic [BIT_W-1:0] bit_w;
  logic [CH_W-1:0]  chan_w;

  st_fp_detect #(.MIN_IDLE(MIN_IDLE)) det_i (
    .clk          (clk),
    .rst          (rst),
    .fp           (fp),
    .at_frame_end (at_frame_end),
    .frame_start  (frame_start),
    .slip         (slip),
    .fmt_alt      (fmt_alt),
    .fmt_lock     (fmt_lock)
  );

  st_bit_timer #(.BASE_CHANS(BASE_CHANS), .BITS_PER_CH(BITS_PER_CH)) tmr_i (
    .clk          (clk),
    .rst          (rst),
    .frame_start  (frame_start),
    .rate_sel     (rate_sel),
    .clk_mode     (clk_mode),
    .tx_en        (tx_en),
    .smp_en       (smp_en),
    .bit_cnt      (bit_w),
    .chan_cnt     (chan_w),
    .at_frame_end (at_frame_end)
  );

  assign bit_cnt  = 3'(bit_w);
  assign chan_cnt = 7'(chan_w);

  // active-low pulse: launch on falling edge, capture on rising; else swapped
  assign tx_on_fall  = !fmt_alt;
  assign smp_on_fall = fmt_alt;

  AST_SLIP_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(slip) |-> $past(frame_start)); // R7
  AST_ONE_CLK_BITS: assert property (@(posedge clk) disable iff (rst)
    (rate_sel == RATE_4M || rate_sel == RATE_8M) |-> (tx_en && smp_en)); // R9

endmodule

// File: tb/st_tdm_timing_tb_top.sv
module st_tdm_timing_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fp = 1'b1;
  logic [1:0] rate_sel = 2'd0;
  logic       clk_mode = 1'b0;
  logic       tx_en, smp_en, tx_on_fall, smp_on_fall, fmt_alt, fmt_lock, slip;
  logic [2:0] bit_cnt;
  logic [6:0] chan_cnt;

  int checks = 0;
  int errors = 0;
  int k = 0;
  logic idle_lvl = 1'b1;
  bit done = 1'b0;

  always #4 clk = ~clk;

  st_tdm_timing dut_i (
    .clk(clk), .rst(rst), .fp(fp), .rate_sel(rate_sel), .clk_mode(clk_mode),
    .tx_en(tx_en), .smp_en(smp_en), .tx_on_fall(tx_on_fall),
    .smp_on_fall(smp_on_fall), .bit_cnt(bit_cnt), .chan_cnt(chan_cnt),
    .fmt_alt(fmt_alt), .fmt_lock(fmt_lock), .slip(slip)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (k=%0d)", tag, act, exp, k);
    end
  endtask

  task automatic do_reset(input logic [1:0] r, input logic m, input logic idle);
    @(negedge clk);
    rst = 1'b1; rate_sel = r; clk_mode = m; idle_lvl = idle; fp = idle;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  // drive pulse edge now; return at the sample point after the start edge
  task automatic pulse(input logic pol);
    fp = pol;
    @(negedge clk);
    k = 0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      k++;
      if (k == 1) fp = idle_lvl;
    end
  endtask

  function automatic int exp_bit(input int kk, input int cpb);
    return (kk / cpb) % 8;
  endfunction
  function automatic int exp_chan(input int kk, input int cpb, input int nch);
    return (kk / (cpb * 8)) % nch;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; fp = 1'b1; rate_sel = 2'd0; clk_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R8 bit_cnt", bit_cnt, 0);
    chk("R8 chan_cnt", chan_cnt, 0);
    chk("R8 tx_en", tx_en, 1);
    chk("R8 smp_en", smp_en, 0);
    chk("R8 fmt_lock", fmt_lock, 0);
    chk("R8 slip", slip, 0);
    chk("R6 default tx_on_fall", tx_on_fall, 1);
    chk("R6 default smp_on_fall", smp_on_fall, 0);
  endtask

  task automatic t_low_pulse_double();
    do_reset(2'd0, 1'b0, 1'b1);
    pulse(1'b0);
    chk("R4 bit zero", bit_cnt, 0);
    chk("R4 chan zero", chan_cnt, 0);
    chk("R7 first start no slip", slip, 0);
    chk("R2 tx first cycle", tx_en, 1);
    chk("R2 no smp first cycle", smp_en, 0);
    step(1);
    chk("R2 smp second cycle", smp_en, 1);
    chk("R2 no tx second cycle", tx_en, 0);
    step(36);
    chk("R3 R4 bit at k37", bit_cnt, exp_bit(37, 2));
    chk("R3 R4 chan at k37", chan_cnt, exp_chan(37, 2, 32));
    chk("R5 no lock yet", fmt_lock, 0);
    step(511 - 37);
    chk("R1 R3 last bit", bit_cnt, 7);
    chk("R1 R3 last chan 31", chan_cnt, 31);
    pulse(1'b0);
    chk("R3 chan wrap", chan_cnt, 0);
    chk("R7 on time no slip", slip, 0);
    chk("R5 lock", fmt_lock, 1);
    chk("R5 low level", fmt_alt, 0);
    chk("R6 tx on fall", tx_on_fall, 1);
    chk("R6 smp on rise", smp_on_fall, 0);
    step(99);
    pulse(1'b0);
    chk("R7 early pulse slip", slip, 1);
    chk("R4 resync bit", bit_cnt, 0);
    chk("R4 resync chan", chan_cnt, 0);
    step(1);
    chk("R7 slip one cycle", slip, 0);
  endtask

  task automatic t_high_pulse_double();
    do_reset(2'd0, 1'b0, 1'b0);
    pulse(1'b1);
    chk("R5 single pulse no lock", fmt_lock, 0);
    step(511);
    pulse(1'b1);
    chk("R5 lock high", fmt_lock, 1);
    chk("R5 high level", fmt_alt, 1);
    chk("R6 tx on rise", tx_on_fall, 0);
    chk("R6 smp on fall", smp_on_fall, 1);
    chk("R7 on time no slip", slip, 0);
  endtask

  task automatic t_rate4();
    do_reset(2'd1, 1'b1, 1'b1);
    pulse(1'b0);
    chk("R2 both strobes k0 tx", tx_en, 1);
    chk("R2 both strobes k0 smp", smp_en, 1);
    step(1);
    chk("R2 both strobes k1 tx", tx_en, 1);
    chk("R2 both strobes k1 smp", smp_en, 1);
    step(12);
    chk("R1 bit at k13", bit_cnt, exp_bit(13, 1));
    chk("R1 chan at k13", chan_cnt, exp_chan(13, 1, 64));
    step(511 - 13);
    chk("R3 last chan 63", chan_cnt, 63);
    pulse(1'b0);
    chk("R7 on time no slip", slip, 0);
    chk("R6 neg pulse tx on fall", tx_on_fall, 1);
    chk("R5 lock equal mode", fmt_lock, 1);
  endtask

  task automatic t_rate8_mode_ignored();
    do_reset(2'd2, 1'b0, 1'b0);
    pulse(1'b1);
    step(1);
    chk("R9 smp every cycle", smp_en, 1);
    chk("R9 tx every cycle", tx_en, 1);
    step(12);
    chk("R9 bit at k13", bit_cnt, exp_bit(13, 1));
    chk("R9 chan at k13", chan_cnt, exp_chan(13, 1, 128));
    step(1023 - 13);
    chk("R3 last chan 127", chan_cnt, 127);
    chk("R3 last bit", bit_cnt, 7);
    pulse(1'b1);
    chk("R7 on time no slip", slip, 0);
    chk("R6 pos pulse tx on rise", tx_on_fall, 0);
    chk("R6 pos pulse smp on fall", smp_on_fall, 1);
  endtask

  initial begin
    t_reset();
    t_low_pulse_double();
    t_high_pulse_double();
    t_rate4();
    t_rate8_mode_ignored();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule